// File: doc/BRIEF.md
# Debug halt and step control register

This block is one 32-bit register on a plain register bus. A debugger uses it to stop a processor core, let it run again, or let it execute one instruction at a time. Writes are guarded by a 16-bit key in the upper half of the write word; a write without the key changes nothing. Reads return the control bits together with live core status and two sticky event flags. The sticky flags report a core reset and an instruction retirement, and they clear once the register has been read.

Internally a three-state sequencer (running, halted, stepping) turns the control bits into a stop request for the core. Core-side inputs are single-cycle pulses (core reset, instruction retired, transfer start, transfer done) and level flags (lockup, sleep). The register bus has no flow control: a write takes effect at the clock edge where `bus_wr_en` is high. Read data is combinational and valid in the same cycle as `bus_rd_en`. The sticky flags clear at the end of that read cycle.

Top module: `dbg_halt_ctl`

## Requirements
- R1: A write at the register address changes the control bits only if wr_data[31:16] equals 0xA05F. A write with any other key, or with the key at another address, leaves all state and outputs unchanged.
- R2: Read word layout: bit0 debug enable, bit1 halt, bit2 step, bit3 mask, bit16 register-ready, bit17 halted, bit18 sleeping, bit19 lockup, bit24 retire-sticky, bit25 reset-sticky. Every other bit reads 0. A read at any other address returns 0. Writes use bits 3:0 with the same meaning.
- R3: The reset-sticky bit sets one cycle after a `core_reset_i` pulse and clears after a read of the register. If the pulse arrives in the same cycle as a read, that read returns the old value and the bit stays set.
- R4: The retire-sticky bit follows the same set, clear and same-cycle rules as R3, driven by `core_retire_i`.
- R5: While running, debug enable and halt both 1 put the unit in the halted state. `core_halt_o` and the halted bit go to 1 on the second rising edge after the write.
- R6: While halted, a keyed write with enable 1, halt 0 and step 0 returns the unit to running at the write's edge.
- R7: While halted, a keyed write with enable 1, halt 0 and step 1 releases the core until exactly one `core_retire_i` pulse. The unit is halted again after the edge of that pulse.
- R8: `irq_mask_o` equals enable AND mask. `step_en_o` equals enable AND step.
- R9: With debug enable 0 the halt, step and mask bits have no effect. Clearing enable while halted returns the unit to running within two edges.
- R10: Register-ready goes to 0 after a `xfer_start_i` pulse and to 1 after a `xfer_done_i` pulse. If both pulse in the same cycle, start wins.
- R11: The sleeping and lockup read bits follow `core_sleep_i` and `core_lockup_i` in the same cycle.
- R12: After `rst_n` reset the control bits are 0, the unit is running, register-ready is 1, the sticky bits are 0 and the register reads 0x00010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the debug logic |
| bus_addr | input | ADDR_W | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write word, key in bits 31:16 |
| bus_rd_en | input | 1 | Read strobe; also clears the sticky bits |
| bus_rd_data | output | 32 | Read word, valid while bus_rd_en is high |
| core_reset_i | input | 1 | Pulse: the core was reset |
| core_retire_i | input | 1 | Pulse: one instruction retired |
| core_lockup_i | input | 1 | Level: core is locked up |
| core_sleep_i | input | 1 | Level: core is sleeping |
| xfer_start_i | input | 1 | Pulse: a core-register transfer begins |
| xfer_done_i | input | 1 | Pulse: the core-register transfer finished |
| core_halt_o | output | 1 | Stop request to the core (halted state) |
| step_en_o | output | 1 | Single-step enabled |
| irq_mask_o | output | 1 | Mask pending-service, timer and external interrupts |

## Verification
The bench writes bad keys and keyed writes to the wrong address. A gate that checked only part of the key or ignored the address would let the read-back control bits change. It reads the register in the same cycle as a reset or retire pulse. A sticky flag that lets the clear win would lose the event and read 0 on the following read. In a single step the core must stay released across idle cycles and stop after exactly one retire pulse. A sequencer that re-halts at once, or that never re-halts, shows up on `core_halt_o`. Clearing enable while halted must release the core, and a stale-state design would keep it stopped.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_LSB = 16;
  localparam logic [15:0] WR_KEY = 16'hA05F;

  // read-word bit positions of status fields
  localparam int RB_READY  = 16;
  localparam int RB_HALTED = 17;
  localparam int RB_SLEEP  = 18;
  localparam int RB_LOCKUP = 19;
  localparam int RB_RETIRE = 24;
  localparam int RB_RESET  = 25;

  localparam int N_STICKY = 2;
  localparam int SK_RETIRE = 0;
  localparam int SK_RESET  = 1;

  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctl_t;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STEP = 2'd2
  } run_st_e;
endpackage

// File: rtl/dbg_key_gate.sv
module dbg_key_gate
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_ok,
  output ctl_t              wr_ctl,
  output ctl_t              ctl_q
);
  logic key_match;
  logic unused_rsvd;

  assign key_match   = (wr_data[WORD_W-1:KEY_LSB] == WR_KEY);
  assign wr_ok       = wr_en && (addr == REG_ADDR) && key_match;
  assign wr_ctl      = ctl_t'(wr_data[3:0]);
  assign unused_rsvd = ^wr_data[KEY_LSB-1:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_ok) ctl_q <= wr_ctl;
  end

  // R1
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_match) |=> $stable(ctl_q));
endmodule

// File: rtl/dbg_sticky_flag.sv
module dbg_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_clr_i,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_i | (flag_q & ~rd_clr_i);
  end

  // R3 R4: an event is never lost, even when it meets a read
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
endmodule

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
  import dbg_halt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl_q,
  input  logic wr_ok,
  input  ctl_t wr_ctl,
  input  logic retire_i,
  output logic halted_o
);
  run_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: begin
        if (ctl_q.en && ctl_q.halt) st_d = ST_HALT;
      end
      ST_HALT: begin
        if (!ctl_q.en)
          st_d = ST_RUN;
        else if (wr_ok && wr_ctl.en && !wr_ctl.halt)
          st_d = wr_ctl.step ? ST_STEP : ST_RUN;
      end
      ST_STEP: begin
        if (!ctl_q.en)                    st_d = ST_RUN;
        else if (retire_i || ctl_q.halt)  st_d = ST_HALT;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign halted_o = (st_q == ST_HALT);

  // R5
  halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && ctl_q.en && ctl_q.halt) |=> halted_o);
  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STEP && ctl_q.en && retire_i) |=> halted_o);
  // R9
  dis_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && st_q != ST_RUN) |=> (st_q == ST_RUN));
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wr_data,
  input  logic              bus_rd_en,
  output logic [31:0]       bus_rd_data,
  input  logic              core_reset_i,
  input  logic              core_retire_i,
  input  logic              core_lockup_i,
  input  logic              core_sleep_i,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  output logic              core_halt_o,
  output logic              step_en_o,
  output logic              irq_mask_o
);
  logic                wr_ok;
  ctl_t                wr_ctl;
  ctl_t                ctl_q;
  logic                halted;
  logic                rd_hit;
  logic                ready_q;
  logic [N_STICKY-1:0] sk_set;
  logic [N_STICKY-1:0] sk_q;
  logic [WORD_W-1:0]   word;

  dbg_key_gate #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_gate (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr_en),
    .wr_data(bus_wr_data), .wr_ok(wr_ok), .wr_ctl(wr_ctl), .ctl_q(ctl_q)
  );

  dbg_run_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .wr_ok(wr_ok),
    .wr_ctl(wr_ctl), .retire_i(core_retire_i), .halted_o(halted)
  );

  assign rd_hit = bus_rd_en && (bus_addr == REG_ADDR);

  assign sk_set[SK_RETIRE] = core_retire_i;
  assign sk_set[SK_RESET]  = core_reset_i;

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    dbg_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(sk_set[g]),
      .rd_clr_i(rd_hit), .flag_q(sk_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ready_q <= 1'b1;
    else if (xfer_start_i) ready_q <= 1'b0;
    else if (xfer_done_i)  ready_q <= 1'b1;
  end

  always_comb begin
    word            = '0;
    word[3:0]       = ctl_q;
    word[RB_READY]  = ready_q;
    word[RB_HALTED] = halted;
    word[RB_SLEEP]  = core_sleep_i;
    word[RB_LOCKUP] = core_lockup_i;
    word[RB_RETIRE] = sk_q[SK_RETIRE];
    word[RB_RESET]  = sk_q[SK_RESET];
  end

  assign bus_rd_data = rd_hit ? word : '0;
  assign core_halt_o = halted;
  assign step_en_o   = ctl_q.en & ctl_q.step;
  assign irq_mask_o  = ctl_q.en & ctl_q.mask;

  // R10
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_i |=> !ready_q);
  // R10
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done_i && !xfer_start_i) |=> ready_q);
  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word[0] |-> (!irq_mask_o && !step_en_o));
endmodule

// File: tb/dbg_halt_ctl_test.sv
module dbg_halt_ctl_test;
  localparam logic [7:0] RA = 8'h10;
  localparam logic [31:0] K = 32'hA05F_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = RA;
  logic bus_wr_en = 0, bus_rd_en = 0;
  logic [31:0] bus_wr_data = '0, bus_rd_data;
  logic core_reset_i = 0, core_retire_i = 0, core_lockup_i = 0, core_sleep_i = 0;
  logic xfer_start_i = 0, xfer_done_i = 0;
  logic core_halt_o, step_en_o, irq_mask_o;

  int errs = 0, checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  dbg_halt_ctl #(.ADDR_W(8), .REG_ADDR(RA)) uut (.*);

  // monitor: compares read data against the scoreboard queue
  initial forever begin
    @(negedge clk); #1;
    if (bus_rd_en) begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (bus_rd_data !== e) begin
        errs++;
        $display("FAIL %s read got %h expected %h", t, bus_rd_data, e);
      end
    end
  end

  task automatic chk(input string t, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %0b expected %0b", t, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [7:0] a = RA);
    @(negedge clk); bus_addr = a; bus_wr_data = d; bus_wr_en = 1;
    @(negedge clk); bus_wr_en = 0; bus_addr = RA;
  endtask

  task automatic rd(input logic [31:0] e, input string t, input logic [7:0] a = RA);
    @(negedge clk); bus_addr = a; bus_rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd_en = 0; bus_addr = RA;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    #3000000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    // R12 reset state
    chk("R12 halt", core_halt_o, 0);
    chk("R12 step", step_en_o, 0);
    chk("R12 mask", irq_mask_o, 0);
    rd(32'h0001_0000, "R12 R2");
    rd(32'h0, "R2 other address", 8'h14);
    // R1 bad key, wrong address
    wr(32'h1234_000F);
    wr(K | 32'h3, 8'h14);
    idle(2);
    chk("R1 halt", core_halt_o, 0);
    rd(32'h0001_0000, "R1");
    // R5 halt
    wr(K | 32'h3); idle(1);
    chk("R5 halt", core_halt_o, 1);
    rd(32'h0003_0003, "R5 R2");
    // R6 resume with mask, R8
    wr(K | 32'h9); idle(1);
    chk("R6 run", core_halt_o, 0);
    chk("R8 mask", irq_mask_o, 1);
    chk("R8 step", step_en_o, 0);
    rd(32'h0001_0009, "R6");
    // R7 single step
    wr(K | 32'h3); idle(1);
    chk("R7 pre-halt", core_halt_o, 1);
    wr(K | 32'h5); idle(3);
    chk("R7 released", core_halt_o, 0);
    chk("R8 step", step_en_o, 1);
    @(negedge clk); core_retire_i = 1;
    @(negedge clk); core_retire_i = 0; #1;
    chk("R7 rehalt", core_halt_o, 1);
    idle(2);
    chk("R7 stays", core_halt_o, 1);
    rd(32'h0103_0005, "R4 set");
    rd(32'h0003_0005, "R4 cleared");
    // R3 reset sticky
    @(negedge clk); core_reset_i = 1;
    @(negedge clk); core_reset_i = 0;
    rd(32'h0203_0005, "R3 set");
    rd(32'h0003_0005, "R3 cleared");
    // R3 event coincident with read
    @(negedge clk); core_reset_i = 1; bus_rd_en = 1;
    exp_q.push_back(32'h0003_0005); tag_q.push_back("R3 same-cycle old");
    @(negedge clk); core_reset_i = 0; bus_rd_en = 0;
    rd(32'h0203_0005, "R3 same-cycle kept");
    // R4 event coincident with read (halted, retire still marks)
    @(negedge clk); core_retire_i = 1; bus_rd_en = 1;
    exp_q.push_back(32'h0003_0005); tag_q.push_back("R4 same-cycle old");
    @(negedge clk); core_retire_i = 0; bus_rd_en = 0;
    rd(32'h0103_0005, "R4 same-cycle kept");
    // R9 clear enable releases, halt bit alone does nothing
    wr(K | 32'h2); idle(3);
    chk("R9 run", core_halt_o, 0);
    chk("R9 step", step_en_o, 0);
    rd(32'h0001_0002, "R9");
    wr(K | 32'hE); idle(3);
    chk("R9 no halt", core_halt_o, 0);
    chk("R9 no mask", irq_mask_o, 0);
    chk("R9 no step", step_en_o, 0);
    wr(K | 32'h2);
    // R10 register-ready
    @(negedge clk); xfer_start_i = 1;
    @(negedge clk); xfer_start_i = 0;
    rd(32'h0000_0002, "R10 drop");
    @(negedge clk); xfer_done_i = 1;
    @(negedge clk); xfer_done_i = 0;
    rd(32'h0001_0002, "R10 rise");
    @(negedge clk); xfer_done_i = 1; xfer_start_i = 1;
    @(negedge clk); xfer_done_i = 0; xfer_start_i = 0;
    rd(32'h0000_0002, "R10 start wins");
    @(negedge clk); xfer_done_i = 1;
    @(negedge clk); xfer_done_i = 0;
    // R11 live status
    @(negedge clk); core_lockup_i = 1; core_sleep_i = 1;
    rd(32'h000D_0002, "R11");
    core_lockup_i = 0;
    rd(32'h0005_0002, "R11 lockup off");
    core_sleep_i = 0;
    idle(2);
    if (exp_q.size() != 0) begin
      errs++; checks++;
      $display("FAIL scoreboard %0d reads unmatched", exp_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule